// File: doc/BRIEF.md
# 1-Wire Master Slot Engine over a UART Loopback

This block runs 1-Wire master operations without any timer of its own. Each bus slot is a single 8-N-1 UART frame: the byte that goes out shapes the low pulse on the shared wire, and the byte that comes back tells what the wire did. The UART's baud rate therefore sets all slot timing. Reset pulses use a slow rate and data slots use a fast one. Both rates change with the selected timing mode, standard or overdrive.

A host issues one command at a time through a valid/ready command port. The commands are reset, write bit, read bit, write byte, read byte and exchange byte. The engine turns each command into a series of requests on a UART client port. A request either changes the baud rate or sends one frame. Each request is answered by a response strobe that carries the looped-back byte or a failure flag. When the command completes, a status code and a result byte are presented with a one-cycle done pulse.

Top module: `owu_slot_engine`

## Requirements
- R1: A reset sends two frames, 0xF0 in standard mode or 0xF8 in overdrive mode, at rate code 0 (9600 baud) or 1 (57600 baud) respectively.
- R2: Only the second reset echo is judged. An echo below the sent frame gives status ready (0). An equal echo gives no-device (1). A greater echo gives error (2).
- R3: Data slots use rate code 2 (115200 baud) in standard mode or 3 (921600 baud) in overdrive mode. The rate code is {data slot, overdrive}.
- R4: A rate-change request (uart_req_setrate=1) is issued only when the needed rate code differs from the rate last set successfully. After reset no rate counts as set.
- R5: A rate change answered with uart_rsp_fail ends the command with status error and result 0. No frame is sent, and the recorded rate stays as it was.
- R6: A write slot sends 0xFF for a 1 and 0x00 for a 0. If any echo differs from its frame, the command ends with status error, but all slots are still sent.
- R7: A read slot sends 0xFF. An echo of exactly 0xFF reads as 1 and any other echo reads as 0. A read-bit command returns the bit in result bit 0.
- R8: Byte writes and byte reads move bits LSB first. A read byte is built by shifting right and inserting each new bit at bit 7.
- R9: In an exchange, each 1 bit of the argument uses a read slot and keeps the reply. Each 0 bit uses a write-0 slot and records a 0.
- R10: Op codes are 0 reset, 1 write bit, 2 read bit, 3 write byte, 4 read byte, 5 exchange byte. busy stays high from accept through the done cycle. done lasts one cycle. At most one UART request is outstanding.
- R11: cmd_ovd is sampled only when a command is accepted. Changes while busy have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Engine idle, command accepted |
| cmd_op | input | 3 | Op code |
| cmd_arg | input | 8 | Bit (bit 0) or byte to write/exchange |
| cmd_ovd | input | 1 | 1 = overdrive timing |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| status | output | 2 | 0 ready, 1 no device, 2 error |
| result | output | 8 | Bit or byte read |
| uart_req_valid | output | 1 | UART request valid |
| uart_req_ready | input | 1 | UART takes the request |
| uart_req_setrate | output | 1 | 1 = rate change, 0 = send frame |
| uart_req_rate | output | 2 | Rate code needed |
| uart_req_frame | output | 8 | Frame to send (0 on rate change) |
| uart_rsp_valid | input | 1 | Response strobe |
| uart_rsp_frame | input | 8 | Looped-back byte |
| uart_rsp_fail | input | 1 | Rate change refused |

## Verification
The assertions assume that the UART client answers each accepted request with exactly one response strobe, and never sends a strobe while no request is outstanding. They also assume that cmd_valid is raised only while cmd_ready is high. The bench's UART model accepts a request only when it is pending. It answers a few cycles later with a single strobe, and the command driver waits for idle before each launch. After every accept the driver inverts cmd_ovd, so the mode input never stays in step with a running command.

// File: rtl/owu_pkg.sv
package owu_pkg;
    localparam int DATA_W     = 8;
    localparam int RATE_W     = 2;
    localparam int CNT_W      = 4;
    localparam int RST_SLOTS  = 2;

    typedef enum logic [2:0] {
        OP_RESET = 3'd0, OP_WBIT = 3'd1, OP_RBIT = 3'd2,
        OP_WBYTE = 3'd3, OP_RBYTE = 3'd4, OP_XBYTE = 3'd5
    } op_e;

    typedef enum logic [1:0] {
        ST_READY = 2'd0, ST_NODEV = 2'd1, ST_ERROR = 2'd2
    } status_e;

    localparam logic [DATA_W-1:0] FRM_RST_STD = 8'hF0;
    localparam logic [DATA_W-1:0] FRM_RST_OVD = 8'hF8;
    localparam logic [DATA_W-1:0] FRM_HIGH    = 8'hFF;
    localparam logic [DATA_W-1:0] FRM_LOW     = 8'h00;

    typedef struct packed {
        op_e               op;
        logic              ovd;
        logic [DATA_W-1:0] arg;
    } cmd_t;

    function automatic logic [RATE_W-1:0] rate_for(op_e op, logic ovd);
        return {op != OP_RESET, ovd};
    endfunction

    function automatic logic [CNT_W-1:0] slots_for(op_e op);
        case (op)
            OP_RESET:                     return CNT_W'(RST_SLOTS);
            OP_WBYTE, OP_RBYTE, OP_XBYTE: return CNT_W'(DATA_W);
            default:                      return CNT_W'(1);
        endcase
    endfunction
endpackage

// File: rtl/owu_rate_tracker.sv
module owu_rate_tracker
    import owu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [RATE_W-1:0] need,
    input  logic              commit,
    output logic              cur_ok
);
    logic [RATE_W-1:0] cur_q;
    logic              known_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q   <= '0;
            known_q <= 1'b0;
        end else if (commit) begin
            cur_q   <= need;
            known_q <= 1'b1;
        end
    end

    assign cur_ok = known_q && (cur_q == need);

    // R4
    commit_known_chk: assert property (@(posedge clk) disable iff (rst)
        commit |=> known_q);
endmodule

// File: rtl/owu_slot_codec.sv
module owu_slot_codec
    import owu_pkg::*;
(
    input  op_e               op,
    input  logic              ovd,
    input  logic              bit_in,
    input  logic [DATA_W-1:0] echo,
    output logic [DATA_W-1:0] tx_frame,
    output logic              read_slot,
    output logic              bit_val,
    output logic              write_bad,
    output status_e           rst_verdict
);
    always_comb begin
        case (op)
            OP_RESET: begin
                tx_frame  = ovd ? FRM_RST_OVD : FRM_RST_STD;
                read_slot = 1'b0;
            end
            OP_WBIT, OP_WBYTE: begin
                tx_frame  = bit_in ? FRM_HIGH : FRM_LOW;
                read_slot = 1'b0;
            end
            OP_XBYTE: begin
                tx_frame  = bit_in ? FRM_HIGH : FRM_LOW;
                read_slot = bit_in;
            end
            default: begin
                tx_frame  = FRM_HIGH;
                read_slot = 1'b1;
            end
        endcase
        bit_val   = (echo == FRM_HIGH);
        write_bad = !read_slot && (op != OP_RESET) && (echo != tx_frame);
        if (echo < tx_frame)       rst_verdict = ST_READY;
        else if (echo == tx_frame) rst_verdict = ST_NODEV;
        else                       rst_verdict = ST_ERROR;
    end
endmodule

// File: rtl/owu_slot_engine.sv
module owu_slot_engine
    import owu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [2:0]        cmd_op,
    input  logic [DATA_W-1:0] cmd_arg,
    input  logic              cmd_ovd,
    output logic              busy,
    output logic              done,
    output logic [1:0]        status,
    output logic [DATA_W-1:0] result,
    output logic              uart_req_valid,
    input  logic              uart_req_ready,
    output logic              uart_req_setrate,
    output logic [RATE_W-1:0] uart_req_rate,
    output logic [DATA_W-1:0] uart_req_frame,
    input  logic              uart_rsp_valid,
    input  logic [DATA_W-1:0] uart_rsp_frame,
    input  logic              uart_rsp_fail
);
    typedef enum logic [2:0] {
        S_IDLE, S_RATE, S_RATE_WAIT, S_SLOT, S_SLOT_WAIT, S_DONE
    } state_e;

    state_e            state_q;
    cmd_t              cmd_q;
    logic [DATA_W-1:0] shreg_q, rx_q;
    logic [CNT_W-1:0]  left_q;
    logic              err_q;
    status_e           stat_q;

    logic [RATE_W-1:0] need_rate;
    logic              cur_ok, commit;
    logic [DATA_W-1:0] tx_frame;
    logic              read_slot, bit_val, write_bad;
    status_e           rst_verdict;

    assign need_rate = rate_for(cmd_q.op, cmd_q.ovd);
    assign commit    = (state_q == S_RATE_WAIT) && uart_rsp_valid && !uart_rsp_fail;

    owu_rate_tracker i_rate (
        .clk(clk), .rst(rst), .need(need_rate), .commit(commit), .cur_ok(cur_ok)
    );

    owu_slot_codec i_codec (
        .op(cmd_q.op), .ovd(cmd_q.ovd), .bit_in(shreg_q[0]), .echo(uart_rsp_frame),
        .tx_frame(tx_frame), .read_slot(read_slot), .bit_val(bit_val),
        .write_bad(write_bad), .rst_verdict(rst_verdict)
    );

    assign cmd_ready        = (state_q == S_IDLE);
    assign busy             = (state_q != S_IDLE);
    assign done             = (state_q == S_DONE);
    assign status           = stat_q;
    assign result           = rx_q;
    assign uart_req_setrate = (state_q == S_RATE);
    assign uart_req_valid   = (state_q == S_SLOT) || ((state_q == S_RATE) && !cur_ok);
    assign uart_req_rate    = need_rate;
    assign uart_req_frame   = (state_q == S_SLOT) ? tx_frame : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= S_IDLE;
            cmd_q   <= '0;
            shreg_q <= '0;
            rx_q    <= '0;
            left_q  <= '0;
            err_q   <= 1'b0;
            stat_q  <= ST_READY;
        end else begin
            case (state_q)
                S_IDLE: if (cmd_valid) begin
                    cmd_q   <= '{op: op_e'(cmd_op), ovd: cmd_ovd, arg: cmd_arg};
                    shreg_q <= cmd_arg;
                    rx_q    <= '0;
                    left_q  <= slots_for(op_e'(cmd_op));
                    err_q   <= 1'b0;
                    state_q <= S_RATE;
                end
                S_RATE: begin
                    if (cur_ok)              state_q <= S_SLOT;
                    else if (uart_req_ready) state_q <= S_RATE_WAIT;
                end
                S_RATE_WAIT: if (uart_rsp_valid) begin
                    if (uart_rsp_fail) begin
                        stat_q  <= ST_ERROR;
                        state_q <= S_DONE;
                    end else begin
                        state_q <= S_SLOT;
                    end
                end
                S_SLOT: if (uart_req_ready) state_q <= S_SLOT_WAIT;
                S_SLOT_WAIT: if (uart_rsp_valid) begin
                    shreg_q <= shreg_q >> 1;
                    left_q  <= left_q - 1'b1;
                    if (cmd_q.op == OP_RBIT)
                        rx_q <= {{(DATA_W-1){1'b0}}, bit_val};
                    else if (cmd_q.op != OP_RESET && cmd_q.op != OP_WBIT && cmd_q.op != OP_WBYTE)
                        rx_q <= {read_slot && bit_val, rx_q[DATA_W-1:1]};
                    if (write_bad) err_q <= 1'b1;
                    if (left_q == CNT_W'(1)) begin
                        if (cmd_q.op == OP_RESET)        stat_q <= rst_verdict;
                        else if (err_q || write_bad)     stat_q <= ST_ERROR;
                        else                             stat_q <= ST_READY;
                        state_q <= S_DONE;
                    end else begin
                        state_q <= S_SLOT;
                    end
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    // R10
    single_req_chk: assert property (@(posedge clk) disable iff (rst)
        (uart_req_valid && uart_req_ready) |=> !uart_req_valid);
    // R10
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (uart_req_valid && !uart_req_ready) |=> (uart_req_valid && $stable(uart_req_frame)));
    // R11
    mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(cmd_q.ovd));
    // R1
    reset_rate_chk: assert property (@(posedge clk) disable iff (rst)
        (uart_req_valid && !uart_req_setrate && cmd_q.op == OP_RESET) |-> !uart_req_rate[1]);
    // R5
    fail_done_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_RATE_WAIT && uart_rsp_valid && uart_rsp_fail) |=> (done && status == ST_ERROR));
endmodule

// File: tb/test_owu_slot_engine.sv
module test_owu_slot_engine;
    import owu_pkg::*;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cmd_valid = 1'b0;
    logic       cmd_ready;
    logic [2:0] cmd_op = '0;
    logic [7:0] cmd_arg = '0;
    logic       cmd_ovd = 1'b0;
    logic       busy, done;
    logic [1:0] status;
    logic [7:0] result;
    logic       uart_req_valid, uart_req_setrate;
    logic       uart_req_ready = 1'b0;
    logic [1:0] uart_req_rate;
    logic [7:0] uart_req_frame;
    logic       uart_rsp_valid = 1'b0;
    logic [7:0] uart_rsp_frame = '0;
    logic       uart_rsp_fail = 1'b0;

    always #2 clk = ~clk;

    owu_slot_engine i_owu_slot_engine (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_op(cmd_op), .cmd_arg(cmd_arg), .cmd_ovd(cmd_ovd), .busy(busy),
        .done(done), .status(status), .result(result),
        .uart_req_valid(uart_req_valid), .uart_req_ready(uart_req_ready),
        .uart_req_setrate(uart_req_setrate), .uart_req_rate(uart_req_rate),
        .uart_req_frame(uart_req_frame), .uart_rsp_valid(uart_rsp_valid),
        .uart_rsp_frame(uart_rsp_frame), .uart_rsp_fail(uart_rsp_fail)
    );

    int checks = 0;
    int fails  = 0;
    logic [10:0] exp_req_q[$];   // {setrate, rate, frame}
    logic [9:0]  exp_res_q[$];   // {status, result}
    logic [7:0]  echo_q[$];
    logic        rate_fail_next = 1'b0;

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic exp_rate(input logic [1:0] r);
        exp_req_q.push_back({1'b1, r, 8'h00});
    endtask

    task automatic exp_frame(input logic [1:0] r, input logic [7:0] f);
        exp_req_q.push_back({1'b0, r, f});
    endtask

    task automatic run_op(input logic [2:0] op, input logic [7:0] arg, input logic ovd,
                          input logic [1:0] st, input logic [7:0] res);
        exp_res_q.push_back({st, res});
        @(negedge clk);
        while (!cmd_ready) @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_arg = arg; cmd_ovd = ovd;
        @(negedge clk);
        cmd_valid = 1'b0;
        cmd_ovd   = ~ovd;   // R11: flipping while busy must not matter
        do @(negedge clk); while (busy);
    endtask

    // UART client model and request scoreboard
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && uart_req_valid) begin
                logic [10:0] got, want;
                logic        is_rate;
                logic [7:0]  echo;
                got = {uart_req_setrate, uart_req_rate, uart_req_setrate ? 8'h00 : uart_req_frame};
                is_rate = uart_req_setrate;
                echo = uart_req_frame;
                uart_req_ready = 1'b1;
                @(negedge clk);
                uart_req_ready = 1'b0;
                if (exp_req_q.size() == 0) check("R4 unexpected UART request", {5'd0, got}, 16'hFFFF);
                else begin
                    want = exp_req_q.pop_front();
                    check("R1/R3/R4/R6 UART request", {5'd0, got}, {5'd0, want});
                end
                repeat (2) @(negedge clk);
                uart_rsp_valid = 1'b1;
                if (is_rate) begin
                    uart_rsp_fail  = rate_fail_next;
                    rate_fail_next = 1'b0;
                    uart_rsp_frame = 8'h00;
                end else begin
                    uart_rsp_fail  = 1'b0;
                    uart_rsp_frame = (echo_q.size() != 0) ? echo_q.pop_front() : echo;
                end
                @(negedge clk);
                uart_rsp_valid = 1'b0;
                uart_rsp_fail  = 1'b0;
            end
        end
    end

    // Result monitor
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && done) begin
                if (exp_res_q.size() == 0) check("R10 unexpected done", 16'h0, 16'hFFFF);
                else begin
                    logic [9:0] e;
                    e = exp_res_q.pop_front();
                    check("R2/R5/R7/R8/R9 result", {6'd0, status, result}, {6'd0, e});
                end
                @(negedge clk);
                check("R10 done one cycle, busy drops", {14'd0, done, busy}, 16'h0);
            end
        end
    end

    task automatic report;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R10 reset state", {13'd0, busy, done, uart_req_valid}, 16'h0);
        check("R10 reset ready", {15'd0, cmd_ready}, 16'h1);

        // R1 R2: presence, first echo ignored
        exp_rate(2'd0); exp_frame(2'd0, 8'hF0); exp_frame(2'd0, 8'hF0);
        echo_q.push_back(8'hF0); echo_q.push_back(8'h90);
        run_op(3'd0, 8'h00, 1'b0, 2'd0, 8'h00);
        // R2 no device, R4 no rate request
        exp_frame(2'd0, 8'hF0); exp_frame(2'd0, 8'hF0);
        echo_q.push_back(8'h00); echo_q.push_back(8'hF0);
        run_op(3'd0, 8'h00, 1'b0, 2'd1, 8'h00);
        // R2 bus error
        exp_frame(2'd0, 8'hF0); exp_frame(2'd0, 8'hF0);
        echo_q.push_back(8'hF0); echo_q.push_back(8'hF4);
        run_op(3'd0, 8'h00, 1'b0, 2'd2, 8'h00);
        // R3 R6 R8 write byte 0xA5 LSB first
        exp_rate(2'd2);
        exp_frame(2'd2, 8'hFF); exp_frame(2'd2, 8'h00); exp_frame(2'd2, 8'hFF); exp_frame(2'd2, 8'h00);
        exp_frame(2'd2, 8'h00); exp_frame(2'd2, 8'hFF); exp_frame(2'd2, 8'h00); exp_frame(2'd2, 8'hFF);
        run_op(3'd3, 8'hA5, 1'b0, 2'd0, 8'h00);
        // R7 R8 read byte -> 0x3C
        for (int i = 0; i < 8; i++) exp_frame(2'd2, 8'hFF);
        echo_q.push_back(8'h80); echo_q.push_back(8'h00); echo_q.push_back(8'hFF); echo_q.push_back(8'hFF);
        echo_q.push_back(8'hFF); echo_q.push_back(8'hFF); echo_q.push_back(8'hFE); echo_q.push_back(8'h7F);
        run_op(3'd4, 8'h00, 1'b0, 2'd0, 8'h3C);
        // R6 write 1 with bad echo
        exp_frame(2'd2, 8'hFF); echo_q.push_back(8'h7F);
        run_op(3'd1, 8'h01, 1'b0, 2'd2, 8'h00);
        // R9 exchange 0x0F -> 0x05
        for (int i = 0; i < 4; i++) exp_frame(2'd2, 8'hFF);
        for (int i = 0; i < 4; i++) exp_frame(2'd2, 8'h00);
        echo_q.push_back(8'hFF); echo_q.push_back(8'h00); echo_q.push_back(8'hFF); echo_q.push_back(8'h00);
        for (int i = 0; i < 4; i++) echo_q.push_back(8'h00);
        run_op(3'd5, 8'h0F, 1'b0, 2'd0, 8'h05);
        // R3 R7 overdrive read bit
        exp_rate(2'd3); exp_frame(2'd3, 8'hFF); echo_q.push_back(8'hFF);
        run_op(3'd2, 8'h00, 1'b1, 2'd0, 8'h01);
        exp_frame(2'd3, 8'hFF); echo_q.push_back(8'hFE);
        run_op(3'd2, 8'h00, 1'b1, 2'd0, 8'h00);
        // R1 overdrive reset
        exp_rate(2'd1); exp_frame(2'd1, 8'hF8); exp_frame(2'd1, 8'hF8);
        echo_q.push_back(8'hF8); echo_q.push_back(8'hC0);
        run_op(3'd0, 8'h00, 1'b1, 2'd0, 8'h00);
        // R5 failed rate change, then retried
        rate_fail_next = 1'b1;
        exp_rate(2'd2);
        run_op(3'd1, 8'h00, 1'b0, 2'd2, 8'h00);
        exp_rate(2'd2); exp_frame(2'd2, 8'h00);
        run_op(3'd1, 8'h00, 1'b0, 2'd0, 8'h00);

        repeat (10) @(negedge clk);
        check("R4 all expected requests seen", 16'(exp_req_q.size()), 16'h0);
        check("R10 all results seen", 16'(exp_res_q.size()), 16'h0);
        report();
    end
endmodule